// File: doc/BRIEF.md
# Timer compare match unit

This block watches a free-running timer value and compares it against a programmed compare register of the same width. When the two become equal, the unit performs one of four actions chosen by a 4-bit mode input: it drives its output pin high, drives it low, only raises an interrupt flag, or fires a special event. The special event pulses a request that resets the external timer and, on instances built with the option, a request that starts an analog-to-digital conversion, provided that a converter enable input is high.

Every action is tied to the first cycle of equality. While the timer stays equal to the compare value, nothing fires again. The interrupt flag stays set until software clears it through a dedicated clear input. The mode value 0000 turns the unit off and returns its pin, flag and match history to their reset state. Any mode outside 0000 and the compare group 10xx leaves the unit idle: matches are ignored, and the pin and flag keep their values.

The block moves no data stream. All of its inputs and outputs are plain level or pulse control signals, with no valid/ready handshake and no back-pressure.

Top module: `cmp_match_unit`

## Requirements
- R1: After reset, pin_o, flag_o, tmr_rst_o and conv_start_o are all 0.
- R2: In mode 4'b1000, a match sets pin_o to 1 and flag_o to 1 on the clock edge that ends the first cycle of equality.
- R3: In mode 4'b1001, a match clears pin_o to 0 and sets flag_o to 1 on the next edge.
- R4: In mode 4'b1010, a match sets flag_o to 1 and leaves pin_o unchanged.
- R5: In mode 4'b1011, a match sets flag_o to 1 and drives tmr_rst_o high for exactly one cycle. pin_o is unchanged.
- R6: conv_start_o is a one-cycle pulse that coincides with a tmr_rst_o pulse, and only when conv_en_i was high in the match cycle. It is constantly 0 when the parameter HAS_CONV is 0.
- R7: A match is the first cycle in which tmr_i equals cmp_i while the mode is in the compare group (mode[3:2] = 2'b10). This includes the cycle in which the mode enters that group while the two values are already equal. Continued equality fires no further action, and neither does switching between compare modes.
- R8: Mode 4'b0000 clears pin_o, flag_o and the pulse outputs on the next edge, and it clears the match history.
- R9: flag_clr_i clears flag_o on the next edge. If a match arrives in the same cycle, the set wins.
- R10: Modes that are neither 4'b0000 nor 10xx produce no match action. pin_o holds its value, and flag_o changes only through flag_clr_i.
- R11: pin_o holds its last value between matches that change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Operating mode (encodings in R2 to R10) |
| cmp_i | input | TMR_W | Compare value |
| tmr_i | input | TMR_W | Current timer value |
| flag_clr_i | input | 1 | Software clear of the interrupt flag |
| conv_en_i | input | 1 | Converter enable; gates conv_start_o |
| pin_o | output | 1 | Output pin register |
| flag_o | output | 1 | Interrupt flag |
| tmr_rst_o | output | 1 | One-cycle timer reset request |
| conv_start_o | output | 1 | One-cycle conversion start request |

## Verification
The hardest situations to reach are the ones where several things coincide at the moment of equality. One is a match that lands in the same cycle as a flag clear. Another is a mode change into the compare group while the timer already equals the compare value. A third is equality that persists across a switch from one compare mode to another. Directed sequences set up each of these on purpose. A long stretch then follows with timer and compare values drawn from a range of only four values, so that equality starts, persists and ends often while the mode, the clear and the converter enable change at random. A behavioural model checks every clock of that stretch.

// File: rtl/cmu_pkg.sv
package cmu_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF     = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_PIN_HI  = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_PIN_LO  = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_FLAG    = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_EVENT   = 4'b1011;

  typedef enum logic [2:0] {
    ACT_NONE      = 3'd0,
    ACT_PIN_HI    = 3'd1,
    ACT_PIN_LO    = 3'd2,
    ACT_FLAG_ONLY = 3'd3,
    ACT_EVENT     = 3'd4
  } act_e;

  function automatic act_e mode_to_act(input logic [MODE_W-1:0] m);
    act_e a;
    case (m)
      MODE_PIN_HI: a = ACT_PIN_HI;
      MODE_PIN_LO: a = ACT_PIN_LO;
      MODE_FLAG:   a = ACT_FLAG_ONLY;
      MODE_EVENT:  a = ACT_EVENT;
      default:     a = ACT_NONE;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/cmu_mode_decode.sv
module cmu_mode_decode
  import cmu_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              off_o,
  output logic              cmp_en_o,
  output act_e              act_o
);

  always_comb begin
    act_o    = mode_to_act(mode_i);
    off_o    = (mode_i == MODE_OFF);
    cmp_en_o = (act_o != ACT_NONE);
  end

endmodule

// File: rtl/cmu_match_detect.sv
module cmu_match_detect #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [TMR_W-1:0] tmr_i,
  input  logic [TMR_W-1:0] cmp_i,
  output logic             hit_o
);

  logic eq;
  logic eq_q;

  // Equality is only remembered while compare is enabled. Entering the
  // compare group with equal values therefore counts as a fresh match.
  assign eq    = (tmr_i == cmp_i);
  assign hit_o = en_i & eq & ~eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= en_i & eq;
  end

endmodule

// File: rtl/cmu_action.sv
module cmu_action
  import cmu_pkg::*;
#(
  parameter bit HAS_CONV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_i,
  input  logic hit_i,
  input  act_e act_i,
  input  logic flag_clr_i,
  input  logic conv_en_i,
  output logic pin_o,
  output logic flag_o,
  output logic tmr_rst_o,
  output logic conv_start_o
);

  logic pin_d, flag_d, rst_d;
  logic ev_hit;

  assign ev_hit = hit_i & (act_i == ACT_EVENT);

  always_comb begin
    pin_d  = pin_o;
    flag_d = flag_o;
    rst_d  = 1'b0;
    if (off_i) begin
      pin_d  = 1'b0;
      flag_d = 1'b0;
    end else begin
      if (hit_i && act_i == ACT_PIN_HI) pin_d = 1'b1;
      if (hit_i && act_i == ACT_PIN_LO) pin_d = 1'b0;
      if (hit_i)           flag_d = 1'b1;
      else if (flag_clr_i) flag_d = 1'b0;
      rst_d = ev_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o     <= 1'b0;
      flag_o    <= 1'b0;
      tmr_rst_o <= 1'b0;
    end else begin
      pin_o     <= pin_d;
      flag_o    <= flag_d;
      tmr_rst_o <= rst_d;
    end
  end

  generate
    if (HAS_CONV) begin : g_conv
      logic conv_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) conv_q <= 1'b0;
        else        conv_q <= ev_hit & conv_en_i & ~off_i;
      end
      assign conv_start_o = conv_q;
    end else begin : g_no_conv
      assign conv_start_o = conv_en_i & 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmu_pkg::*;
#(
  parameter int TMR_W    = 16,
  parameter bit HAS_CONV = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TMR_W-1:0]  cmp_i,
  input  logic [TMR_W-1:0]  tmr_i,
  input  logic              flag_clr_i,
  input  logic              conv_en_i,
  output logic              pin_o,
  output logic              flag_o,
  output logic              tmr_rst_o,
  output logic              conv_start_o
);

  logic off, cmp_en, hit;
  act_e act;

  cmu_mode_decode u_dec (
    .mode_i   (mode_i),
    .off_o    (off),
    .cmp_en_o (cmp_en),
    .act_o    (act)
  );

  cmu_match_detect #(.TMR_W(TMR_W)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (cmp_en),
    .tmr_i (tmr_i),
    .cmp_i (cmp_i),
    .hit_o (hit)
  );

  cmu_action #(.HAS_CONV(HAS_CONV)) u_act (
    .clk          (clk),
    .rst_n        (rst_n),
    .off_i        (off),
    .hit_i        (hit),
    .act_i        (act),
    .flag_clr_i   (flag_clr_i),
    .conv_en_i    (conv_en_i),
    .pin_o        (pin_o),
    .flag_o       (flag_o),
    .tmr_rst_o    (tmr_rst_o),
    .conv_start_o (conv_start_o)
  );

endmodule

// File: rtl/cmu_checker.sv
module cmu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode_i,
  input logic       flag_clr_i,
  input logic       conv_en_i,
  input logic       pin_o,
  input logic       flag_o,
  input logic       tmr_rst_o,
  input logic       conv_start_o
);

  logic idle_mode;
  assign idle_mode = (mode_i != 4'b0000) && (mode_i[3:2] != 2'b10);

  // R2: a rising pin follows a cycle in set-on-match mode
  assert_pin_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_o) |-> $past(mode_i) == 4'b1000);

  // R3 / R8: a falling pin follows clear-on-match mode or the off mode
  assert_pin_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_o) |-> ($past(mode_i) == 4'b1001 || $past(mode_i) == 4'b0000));

  assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst_o |=> !tmr_rst_o);

  assert_rst_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst_o |-> ($past(mode_i) == 4'b1011 && flag_o));

  assert_conv_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> (tmr_rst_o && $past(conv_en_i)));

  assert_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b0000) |=> (!pin_o && !flag_o && !tmr_rst_o && !conv_start_o));

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_mode && flag_clr_i) |=> !flag_o);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_mode |=> ($stable(pin_o) && !tmr_rst_o));

endmodule

bind cmp_match_unit cmu_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .flag_clr_i   (flag_clr_i),
  .conv_en_i    (conv_en_i),
  .pin_o        (pin_o),
  .flag_o       (flag_o),
  .tmr_rst_o    (tmr_rst_o),
  .conv_start_o (conv_start_o)
);

// File: tb/tb_cmp_match_unit.sv
`timescale 1ns/1ps
module tb_cmp_match_unit;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   mode = 4'b0000;
  logic [W-1:0] cmpv = '0;
  logic [W-1:0] tmr = '0;
  logic         clr = 1'b0;
  logic         cen = 1'b0;
  logic         pin, flag, trst, conv;
  logic         pin_n, flag_n, trst_n, conv_n;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  // reference model state
  bit m_pin = 0, m_flag = 0, m_rst = 0, m_conv = 0, m_prev = 0;

  always #2.5 clk = ~clk;

  cmp_match_unit #(.TMR_W(W), .HAS_CONV(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cmp_i(cmpv), .tmr_i(tmr),
    .flag_clr_i(clr), .conv_en_i(cen), .pin_o(pin), .flag_o(flag),
    .tmr_rst_o(trst), .conv_start_o(conv));

  cmp_match_unit #(.TMR_W(W), .HAS_CONV(1'b0)) dut_nc (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cmp_i(cmpv), .tmr_i(tmr),
    .flag_clr_i(clr), .conv_en_i(cen), .pin_o(pin_n), .flag_o(flag_n),
    .tmr_rst_o(trst_n), .conv_start_o(conv_n));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit cmpg, eq, hit;
    if (!rst_n) begin
      m_pin = 0; m_flag = 0; m_rst = 0; m_conv = 0; m_prev = 0;
    end else begin
      cmpg = (mode[3:2] == 2'b10);
      eq   = (tmr == cmpv);
      hit  = cmpg && eq && !m_prev;
      m_prev = cmpg && eq;
      if (mode == 4'b0000) begin
        m_pin = 0; m_flag = 0; m_rst = 0; m_conv = 0;
      end else begin
        m_rst  = hit && (mode == 4'b1011);
        m_conv = m_rst && cen;
        if (hit && mode == 4'b1000) m_pin = 1;
        if (hit && mode == 4'b1001) m_pin = 0;
        if (hit) m_flag = 1;
        else if (clr) m_flag = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2/R3/R11 model pin", pin, m_pin);
      chk("R4/R9 model flag", flag, m_flag);
      chk("R5 model tmr_rst", trst, m_rst);
      chk("R6 model conv_start", conv, m_conv);
      chk("R6 no-conv instance conv_start", conv_n, 1'b0);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    chk("R1 pin", pin, 0); chk("R1 flag", flag, 0);
    chk("R1 tmr_rst", trst, 0); chk("R1 conv", conv, 0);

    // set on match
    mode = 4'b1000; cmpv = 5; tmr = 3; step();
    tmr = 5; step();
    chk("R2 pin high", pin, 1); chk("R2 flag", flag, 1);
    step();
    clr = 1; step(); clr = 0;
    chk("R9 clear", flag, 0);
    step();
    chk("R7 held equality no refire", flag, 0);

    // switch compare modes while equal: no new match
    mode = 4'b1001; step();
    chk("R7 mode switch while equal", pin, 1);
    chk("R7 mode switch flag", flag, 0);
    tmr = 6; step(); tmr = 5; step();
    chk("R3 pin low", pin, 0); chk("R3 flag", flag, 1);

    // flag-only keeps pin
    mode = 4'b1000; tmr = 6; step(); tmr = 5; step();
    chk("R11 pin high again", pin, 1);
    mode = 4'b1010; tmr = 6; clr = 1; step(); clr = 0;
    chk("R9 clear before flag-only", flag, 0);
    tmr = 5; step();
    chk("R4 flag", flag, 1); chk("R4 pin unchanged", pin, 1);

    // special event with converter enabled
    mode = 4'b1011; cen = 1; tmr = 6; step();
    tmr = 5; step();
    chk("R5 tmr_rst pulse", trst, 1); chk("R6 conv pulse", conv, 1);
    chk("R5 pin unchanged", pin, 1);
    chk("R6 no-conv instance", conv_n, 0);
    step();
    chk("R5 pulse one cycle", trst, 0); chk("R6 pulse one cycle", conv, 0);
    tmr = 6; cen = 0; step(); tmr = 5; step();
    chk("R5 tmr_rst again", trst, 1); chk("R6 gated by enable", conv, 0);

    // idle mode ignores match
    mode = 4'b0100; tmr = 6; step(); tmr = 5; step();
    chk("R10 no pulse", trst, 0); chk("R10 pin hold", pin, 1);
    chk("R10 flag hold", flag, 1);
    clr = 1; step(); clr = 0;
    chk("R9 clear in idle mode", flag, 0);

    // set wins over clear
    mode = 4'b1010; tmr = 6; step();
    tmr = 5; clr = 1; step(); clr = 0;
    chk("R9 set wins", flag, 1);

    // off mode resets, then entering compare while equal matches
    mode = 4'b0000; step();
    chk("R8 pin cleared", pin, 0); chk("R8 flag cleared", flag, 0);
    mode = 4'b1000; step();
    chk("R7 enter compare while equal", pin, 1);
    chk("R7 enter compare flag", flag, 1);

    // random phase, narrow value range
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0: mode = 4'b0000;
        1: mode = 4'b0101;
        2: mode = 4'b1100;
        3, 4: mode = 4'b1000;
        5, 6: mode = 4'b1001;
        7: mode = 4'b1010;
        default: mode = 4'b1011;
      endcase
      if ($urandom_range(0, 3) != 0) mode = mode;
      tmr  = W'($urandom_range(0, 3));
      cmpv = W'($urandom_range(0, 3));
      clr  = ($urandom_range(0, 4) == 0);
      cen  = $urandom_range(0, 1) != 0;
      step();
    end
    finish_run();
  end

endmodule